// File: doc/BRIEF.md
# Windowed Pixel-Write Transfer Engine

This block paces the host's pixel writes into a rectangular update window. Software first supplies the window. This is the inclusive first and last column and row, with a 4-bit pixel format code and a 3-bit data-source selector. The block then works out how many bytes the window needs: bytes per pixel times columns times rows. It accepts that many byte beats on a valid/ready data port and raises `done` for one cycle when the last beat lands. The byte payload goes to frame memory on a separate path and is not part of this block. Only the beats are counted here.

A transfer is armed in one of two ways. A pulse on `src_wr` stands for a write of the source-select register and runs setup at once. A data beat that arrives while no transfer is open runs setup first and counts as the first byte. Setup is refused for parameters that are not allowed. After a refused setup, the block behaves as if the write had not happened.

Every finished window widens a dirty rectangle. The rectangle is the union of all committed windows, and a display refresh can clear it with `dirty_clr`. Back-pressure rule: `dat_ready` is low only in a cycle where `src_wr` is high. A beat is accepted on a rising edge where both `dat_valid` and `dat_ready` are high. The sender may hold `dat_valid` high for any number of cycles.

Top module: `pixwin_xfer_engine`

## Requirements
- R1: Bytes per pixel from `fmt_code`: 0, 1 and 6 give 2; 2 and 3 (three-byte 6:6:6 / 8:8:8) give 3; 4 and 5 (four-byte 6:6:6 / 8:8:8) give 4; codes 7 to 15 give 0, meaning unsupported.
- R2: Setup is refused when `src_sel` > 3, when bytes per pixel is 0, when `win_x1` < `win_x0`, or when `win_y1` < `win_y0`. A refused setup leaves any open transfer and its remaining count unchanged.
- R3: A transfer needs exactly bpp × (`win_x1`−`win_x0`+1) × (`win_y1`−`win_y0`+1) accepted beats. Each accepted beat of an open transfer lowers the remaining count by one.
- R4: A beat accepted with no transfer open runs setup with the current inputs and counts as the first byte. If that setup is refused, the beat is dropped.
- R5: A cycle with `src_wr` high runs setup at once. When setup is allowed, it replaces any open transfer with a fresh full count. `dat_ready` is low in that cycle.
- R6: `done` is high for exactly the one cycle that follows the rising edge on which the final beat was accepted.
- R7: When a window commits, the dirty minimum X/Y drops to the window start if the start is smaller. The 11-bit dirty maximum X/Y rises to start + size if that is larger. The maximum can reach 1024 on a 10-bit axis.
- R8: `dirty_clr` sets the minimum to all ones and the maximum to 0. If a commit falls in the same cycle, the result is the committed window alone.
- R9: After reset, `done` is low, no transfer is open, and the dirty rectangle is in its cleared state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_x0 | input | 10 | First column of the window |
| win_y0 | input | 10 | First row of the window |
| win_x1 | input | 10 | Last column of the window (inclusive) |
| win_y1 | input | 10 | Last row of the window (inclusive) |
| fmt_code | input | 4 | Pixel format code |
| src_sel | input | 3 | Data-source selector; values above 3 are refused |
| src_wr | input | 1 | Source-select write strobe, runs setup |
| dat_valid | input | 1 | Data beat offered |
| dat_ready | output | 1 | Data beat can be taken |
| dirty_clr | input | 1 | Clear the dirty rectangle |
| done | output | 1 | One-cycle window-complete pulse |
| dirty_min_x | output | 10 | Dirty rectangle smallest X |
| dirty_min_y | output | 10 | Dirty rectangle smallest Y |
| dirty_max_x | output | 11 | Dirty rectangle exclusive end X |
| dirty_max_y | output | 11 | Dirty rectangle exclusive end Y |

## Verification
The counting function is tried with several window patterns. A one-pixel window is run for every format code, which separates each entry of the bytes-per-pixel table and shows that zero-size formats drop their bytes. Multi-row windows started by the source strobe and by an idle beat tell the two arming paths apart. A source strobe in the middle of a transfer is tried twice. A refused strobe must leave the old count, and an allowed strobe must restart with the new count, so the two outcomes land on different beat counts. Windows at the far corner of the coordinate space, and a clear that falls in the same cycle as a commit, check the dirty rectangle's 11-bit edge and how the two updates merge.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  localparam int FMT_W = 4;
  localparam int BPP_W = 3;
  localparam int SRC_W = 3;
  localparam logic [SRC_W-1:0] SRC_MAX = 3'd3;

  // bytes per pixel for each format code; 0 marks an unsupported code
  function automatic logic [BPP_W-1:0] bytes_per_px(input logic [FMT_W-1:0] code);
    case (code)
      4'd0, 4'd1, 4'd6: bytes_per_px = 3'd2;
      4'd2, 4'd3:       bytes_per_px = 3'd3;
      4'd4, 4'd5:       bytes_per_px = 3'd4;
      default:          bytes_per_px = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pwx_setup_chk.sv
module pwx_setup_chk
  import pwx_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int CNT_W   = 2*COORD_W + BPP_W
) (
  input  logic [COORD_W-1:0] x0,
  input  logic [COORD_W-1:0] y0,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [FMT_W-1:0]   fmt,
  input  logic [SRC_W-1:0]   src,
  output logic               legal,
  output logic [COORD_W:0]   wid,
  output logic [COORD_W:0]   hgt,
  output logic [CNT_W-1:0]   len
);
  logic [BPP_W-1:0] bpp;

  always_comb begin
    bpp   = bytes_per_px(fmt);
    legal = (src <= SRC_MAX) && (bpp != '0) && (x1 >= x0) && (y1 >= y0);
    wid   = {1'b0, x1} - {1'b0, x0} + 1'b1;
    hgt   = {1'b0, y1} - {1'b0, y0} + 1'b1;
    len   = CNT_W'(bpp) * CNT_W'(wid) * CNT_W'(hgt);
  end
endmodule

// File: rtl/pwx_byte_counter.sv
module pwx_byte_counter #(
  parameter int CNT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_full,
  input  logic             load_first,
  input  logic             step,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] rem,
  output logic             active,
  output logic             commit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign active = (rem != '0);
  assign commit = (step && rem == ONE) || (load_first && len == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)          rem <= '0;
    else if (load_full)  rem <= len;
    else if (load_first) rem <= len - ONE;
    else if (step)       rem <= rem - ONE;
  end
endmodule

// File: rtl/pwx_axis_span.sv
module pwx_axis_span #(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               commit,
  input  logic [COORD_W-1:0] start,
  input  logic [COORD_W:0]   size,
  output logic [COORD_W-1:0] lo,
  output logic [COORD_W:0]   hi
);
  logic [COORD_W:0]   stop;
  logic [COORD_W-1:0] base_lo, nxt_lo;
  logic [COORD_W:0]   base_hi, nxt_hi;

  always_comb begin
    stop    = {1'b0, start} + size;
    base_lo = clr ? '1 : lo;
    base_hi = clr ? '0 : hi;
    nxt_lo  = (commit && start < base_lo) ? start : base_lo;
    nxt_hi  = (commit && stop  > base_hi) ? stop  : base_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '1;
      hi <= '0;
    end else begin
      lo <= nxt_lo;
      hi <= nxt_hi;
    end
  end
endmodule

// File: rtl/pixwin_xfer_engine.sv
module pixwin_xfer_engine
  import pwx_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] win_x0,
  input  logic [COORD_W-1:0] win_y0,
  input  logic [COORD_W-1:0] win_x1,
  input  logic [COORD_W-1:0] win_y1,
  input  logic [FMT_W-1:0]   fmt_code,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic               src_wr,
  input  logic               dat_valid,
  output logic               dat_ready,
  input  logic               dirty_clr,
  output logic               done,
  output logic [COORD_W-1:0] dirty_min_x,
  output logic [COORD_W-1:0] dirty_min_y,
  output logic [COORD_W:0]   dirty_max_x,
  output logic [COORD_W:0]   dirty_max_y
);
  localparam int CNT_W  = 2*COORD_W + BPP_W;
  localparam int N_AXIS = 2;

  logic               legal, active, commit, beat;
  logic               load_full, load_first, step;
  logic [COORD_W:0]   wid, hgt;
  logic [CNT_W-1:0]   len, rem_cnt;

  // latched window of the open transfer, index 0 = X, 1 = Y
  logic [COORD_W-1:0] lat_start [N_AXIS];
  logic [COORD_W:0]   lat_size  [N_AXIS];
  logic [COORD_W-1:0] new_start [N_AXIS];
  logic [COORD_W:0]   new_size  [N_AXIS];
  logic [COORD_W-1:0] span_lo   [N_AXIS];
  logic [COORD_W:0]   span_hi   [N_AXIS];

  assign dat_ready  = ~src_wr;
  assign beat       = dat_valid & dat_ready;
  assign load_full  = src_wr & legal;
  assign load_first = beat & ~active & legal;
  assign step       = beat & active;

  assign new_start[0] = win_x0;
  assign new_start[1] = win_y0;
  assign new_size[0]  = wid;
  assign new_size[1]  = hgt;

  pwx_setup_chk #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_setup (
    .x0(win_x0), .y0(win_y0), .x1(win_x1), .y1(win_y1),
    .fmt(fmt_code), .src(src_sel),
    .legal(legal), .wid(wid), .hgt(hgt), .len(len)
  );

  pwx_byte_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .load_full(load_full), .load_first(load_first), .step(step),
    .len(len), .rem(rem_cnt), .active(active), .commit(commit)
  );

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    logic [COORD_W-1:0] cm_start;
    logic [COORD_W:0]   cm_size;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat_start[a] <= '0;
        lat_size[a]  <= '0;
      end else if (load_full || load_first) begin
        lat_start[a] <= new_start[a];
        lat_size[a]  <= new_size[a];
      end
    end

    // a one-beat commit uses the window being set up this cycle
    assign cm_start = load_first ? new_start[a] : lat_start[a];
    assign cm_size  = load_first ? new_size[a]  : lat_size[a];

    pwx_axis_span #(.COORD_W(COORD_W)) u_span (
      .clk(clk), .rst_n(rst_n), .clr(dirty_clr), .commit(commit),
      .start(cm_start), .size(cm_size),
      .lo(span_lo[a]), .hi(span_hi[a])
    );
  end

  assign dirty_min_x = span_lo[0];
  assign dirty_min_y = span_lo[1];
  assign dirty_max_x = span_hi[0];
  assign dirty_max_y = span_hi[1];

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= commit;
  end
endmodule

// File: rtl/pwx_checker.sv
module pwx_checker #(
  parameter int COORD_W = 10,
  parameter int CNT_W   = 23
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         src_sel,
  input logic               src_wr,
  input logic               dat_valid,
  input logic               dat_ready,
  input logic               dirty_clr,
  input logic               done,
  input logic               commit,
  input logic [CNT_W-1:0]   rem_cnt,
  input logic [COORD_W-1:0] dirty_min_x,
  input logic [COORD_W-1:0] dirty_min_y,
  input logic [COORD_W:0]   dirty_max_x,
  input logic [COORD_W:0]   dirty_max_y
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rem_cnt == '0);

  assert_dirty_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, dirty_min_x} < dirty_max_x) && ({1'b0, dirty_min_y} < dirty_max_y));

  assert_clear_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_clr && !commit) |=> (dirty_min_x == '1) && (dirty_min_y == '1)
                               && (dirty_max_x == '0) && (dirty_max_y == '0));

  assert_bad_src_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wr && src_sel > 3'd3) |=> $stable(rem_cnt));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && dat_ready && rem_cnt != '0) |=> rem_cnt == $past(rem_cnt) - 1'b1);
endmodule

bind pixwin_xfer_engine pwx_checker #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_pwx_checker (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .src_wr(src_wr),
  .dat_valid(dat_valid), .dat_ready(dat_ready), .dirty_clr(dirty_clr),
  .done(done), .commit(commit), .rem_cnt(rem_cnt),
  .dirty_min_x(dirty_min_x), .dirty_min_y(dirty_min_y),
  .dirty_max_x(dirty_max_x), .dirty_max_y(dirty_max_y)
);

// File: tb/pixwin_xfer_engine_bench.sv
module pixwin_xfer_engine_bench;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] win_x0 = '0, win_y0 = '0, win_x1 = '0, win_y1 = '0;
  logic [3:0]    fmt_code = '0;
  logic [2:0]    src_sel = '0;
  logic          src_wr = 1'b0, dat_valid = 1'b0, dirty_clr = 1'b0;
  logic          dat_ready, done;
  logic [CW-1:0] dirty_min_x, dirty_min_y;
  logic [CW:0]   dirty_max_x, dirty_max_y;

  always #10 clk = ~clk;

  pixwin_xfer_engine #(.COORD_W(CW)) u_pixwin_xfer_engine (
    .clk(clk), .rst_n(rst_n),
    .win_x0(win_x0), .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1),
    .fmt_code(fmt_code), .src_sel(src_sel), .src_wr(src_wr),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dirty_clr(dirty_clr),
    .done(done), .dirty_min_x(dirty_min_x), .dirty_min_y(dirty_min_y),
    .dirty_max_x(dirty_max_x), .dirty_max_y(dirty_max_y)
  );

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { int mnx; int mny; int mxx; int mxy; } rect_t;
  rect_t exp_q[$];

  // reference model state
  int m_rem = 0;
  int m_x0 = 0, m_y0 = 0, m_w = 0, m_h = 0;
  int d_mnx = 1023, d_mny = 1023, d_mxx = 0, d_mxy = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int bpp_ref(input int c);
    case (c)
      0, 1, 6: return 2;
      2, 3:    return 3;
      4, 5:    return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit legal_ref();
    return (int'(src_sel) <= 3) && (bpp_ref(int'(fmt_code)) != 0)
           && (win_x1 >= win_x0) && (win_y1 >= win_y0);
  endfunction

  task automatic load_ref();
    m_x0  = int'(win_x0);
    m_y0  = int'(win_y0);
    m_w   = int'(win_x1) - int'(win_x0) + 1;
    m_h   = int'(win_y1) - int'(win_y0) + 1;
    m_rem = bpp_ref(int'(fmt_code)) * m_w * m_h;
  endtask

  task automatic commit_ref();
    rect_t r;
    if (m_x0 < d_mnx) d_mnx = m_x0;
    if (m_y0 < d_mny) d_mny = m_y0;
    if (m_x0 + m_w > d_mxx) d_mxx = m_x0 + m_w;
    if (m_y0 + m_h > d_mxy) d_mxy = m_y0 + m_h;
    r.mnx = d_mnx; r.mny = d_mny; r.mxx = d_mxx; r.mxy = d_mxy;
    exp_q.push_back(r);
  endtask

  // one clock cycle of stimulus: beat, source strobe, clear
  task automatic cyc(input bit v, input bit s, input bit clr);
    bit cm;
    @(negedge clk);
    dat_valid = v; src_wr = s; dirty_clr = clr;
    cm = 1'b0;
    if (s) begin
      if (legal_ref()) load_ref();
    end else if (v) begin
      if (m_rem > 0) begin
        m_rem--; cm = (m_rem == 0);
      end else if (legal_ref()) begin
        load_ref(); m_rem--; cm = (m_rem == 0);
      end
    end
    if (clr) begin d_mnx = 1023; d_mny = 1023; d_mxx = 0; d_mxy = 0; end
    if (cm) commit_ref();
    if (s) begin
      #1;
      chk(dat_ready == 1'b0, "R5", "dat_ready during src_wr", int'(dat_ready), 0);
    end
    @(posedge clk);
    #1;
    dat_valid = 1'b0; src_wr = 1'b0; dirty_clr = 1'b0;
  endtask

  task automatic beats(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
  endtask

  task automatic set_win(input int x0, input int y0, input int x1, input int y1,
                         input int fmt, input int sel);
    win_x0 = CW'(x0); win_y0 = CW'(y0); win_x1 = CW'(x1); win_y1 = CW'(y1);
    fmt_code = 4'(fmt); src_sel = 3'(sel);
  endtask

  task automatic drained(input string tag);
    @(negedge clk);
    #1;
    chk(exp_q.size() == 0, tag, "pending done events", exp_q.size(), 0);
  endtask

  task automatic check_dirty(input string tag);
    chk(int'(dirty_min_x) == d_mnx, tag, "dirty_min_x", int'(dirty_min_x), d_mnx);
    chk(int'(dirty_min_y) == d_mny, tag, "dirty_min_y", int'(dirty_min_y), d_mny);
    chk(int'(dirty_max_x) == d_mxx, tag, "dirty_max_x", int'(dirty_max_x), d_mxx);
    chk(int'(dirty_max_y) == d_mxy, tag, "dirty_max_y", int'(dirty_max_y), d_mxy);
  endtask

  // monitor: every done pulse must match the next expected commit
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected done", 1, 0);
      end else begin
        rect_t r;
        r = exp_q.pop_front();
        chk(int'(dirty_min_x) == r.mnx, "R7", "min_x at done", int'(dirty_min_x), r.mnx);
        chk(int'(dirty_min_y) == r.mny, "R7", "min_y at done", int'(dirty_min_y), r.mny);
        chk(int'(dirty_max_x) == r.mxx, "R7", "max_x at done", int'(dirty_max_x), r.mxx);
        chk(int'(dirty_max_y) == r.mxy, "R7", "max_y at done", int'(dirty_max_y), r.mxy);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(done == 1'b0, "R9", "done after reset", int'(done), 0);
    check_dirty("R9");

    // R3 R5: strobe-started 3x2 window, 2 bytes/pixel = 12 beats
    set_win(2, 3, 4, 4, 0, 1);
    cyc(1'b0, 1'b1, 1'b0);
    beats(11);
    #1 chk(exp_q.size() == 0, "R3", "no early done", exp_q.size(), 0);
    beats(1);
    drained("R3");

    // R4: idle beat starts a one-pixel four-byte window
    set_win(10, 20, 10, 20, 5, 0);
    beats(4);
    drained("R4");

    // R4: idle start, three-byte 2x1 window
    set_win(0, 0, 1, 0, 3, 2);
    beats(6);
    drained("R4");
    check_dirty("R7");

    // R1: one-pixel window for every format code
    for (int c = 0; c < 16; c++) begin
      set_win(5, 5, 5, 5, c, 0);
      beats(bpp_ref(c) == 0 ? 3 : bpp_ref(c));
      drained("R1");
    end

    // R2 R4: illegal source, illegal format, reversed coordinates drop beats
    set_win(1, 1, 1, 1, 0, 6);
    beats(3);
    cyc(1'b0, 1'b1, 1'b0);
    set_win(1, 1, 1, 1, 9, 0);
    beats(3);
    set_win(7, 1, 6, 1, 0, 0);
    cyc(1'b0, 1'b1, 1'b0);
    beats(3);
    set_win(1, 8, 1, 7, 0, 0);
    beats(3);
    drained("R2");
    set_win(1, 1, 1, 1, 0, 0);
    beats(2);
    drained("R2");

    // R2: refused strobe mid-transfer keeps the old count (8 beats)
    set_win(30, 40, 31, 41, 0, 3);
    beats(3);
    src_sel = 3'd5;
    cyc(1'b0, 1'b1, 1'b0);
    src_sel = 3'd3;
    beats(5);
    drained("R2");

    // R5: allowed strobe mid-transfer restarts with the new count
    set_win(30, 40, 31, 41, 0, 3);
    beats(3);
    set_win(50, 60, 50, 60, 4, 0);
    cyc(1'b0, 1'b1, 1'b0);
    beats(4);
    drained("R5");

    // R8: plain clear
    cyc(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check_dirty("R8");
    chk(int'(dirty_min_x) == 1023, "R8", "cleared min_x all ones", int'(dirty_min_x), 1023);

    // R7: window at the far corner, max reaches 1024
    set_win(1020, 1021, 1023, 1023, 0, 0);
    beats(24);
    drained("R7");
    check_dirty("R7");

    // R8: clear in the same cycle as a commit keeps only that window
    set_win(100, 200, 100, 200, 1, 0);
    beats(1);
    cyc(1'b1, 1'b0, 1'b1);
    drained("R8");
    check_dirty("R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule